// File: doc/BRIEF.md
# Controller Pad Input Register Window

This block lets a processor read the button states of two game controllers. The buttons arrive as two 32-bit active-high words from a host-side clock domain. Inside the block, each word passes through its own two-flop synchronizer into the local clock. The low sixteen bits are then rearranged into a fixed, non-linear, active-low two-byte pad word.

A small read-only register window makes three registers visible on a simple read port: the pad word for each player and a status word. A read is requested by raising `rd_en` with an address. The data comes back one local clock later, together with a one-cycle `rd_valid`. Reset is synchronous and active high. It clears the synchronizers, so both pad words read as "nothing pressed" straight after reset.

Top module: `pad_reg_window`

## Requirements
- R1: Each host word reaches the pad registers through exactly two local flops. A change applied before local edge k is not seen by a read sampled at edges k or k+1. It is seen by a read sampled at edge k+2.
- R2: Address 0x1F80_8500 returns the player-one pad word and address 0x1F80_8504 returns the player-two pad word.
- R3: Pad words occupy rd_data[15:0] and rd_data[31:16] is always zero. A host word of all zeros reads as 0x0000_FFFF.
- R4: Address 0x1F80_8508 returns 0x0000_0001.
- R5: Pad bits 7 down to 0 are the inverted host bits 1, 2, 0, 3, 4, 15, 14, 5, in that order.
- R6: Pad bits 15 down to 8 are the inverted host bits 8, 7, 9, 6, 11, 10, 13, 12, in that order.
- R7: When rd_en is sampled high at an edge, rd_valid is high for exactly the following cycle and carries the data. When rd_en is sampled low, rd_valid and rd_data are zero for the following cycle.
- R8: A change on one player's host word never alters the other player's pad register.
- R9: When a host word returns to zero without a local reset, its pad word reads 0x0000_FFFF again once the two flops have settled.
- R10: Host bits 16 to 31 have no effect on any pad word.
- R11: A read of any address other than the three above returns zero with a one-cycle rd_valid.
- R12: While rst is high, the synchronizer flops, rd_valid and rd_data clear. A read issued at the first edge after reset returns 0x0000_FFFF for either pad.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local (processor-side) clock |
| rst | input | 1 | Synchronous active-high reset |
| host_btn_p1 | input | 32 | Player-one button word, active high, host clock domain |
| host_btn_p2 | input | 32 | Player-two button word, active high, host clock domain |
| rd_en | input | 1 | Read request, sampled on the rising edge |
| rd_addr | input | 32 | Read address |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | One-cycle read response strobe |

## Verification
The bound checker watches the read handshake on every cycle. It confirms that rd_valid follows rd_en by exactly one cycle and never appears on its own. It also confirms that the upper half of the returned data stays zero, that the status address returns one, and that unmapped addresses return zero. Some properties can only be shown by the bench's scenarios: the two-edge synchronizer latency, the scrambled bit order of each pad byte, the independence of the two players, recovery to all-released without a local reset, and insensitivity to the upper host bits. The bench shows these with directed reads of chosen button patterns. A behavioural reference model, compared on every clock, covers the rest.

// File: rtl/pad_win_pkg.sv
package pad_win_pkg;

    localparam int BTN_W     = 32;
    localparam int PAD_W     = 16;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int N_PLAYERS = 2;
    localparam int SYNC_DEPTH = 2;
    localparam int SRC_W     = PAD_W;

    localparam logic [ADDR_W-1:0] WIN_BASE   = 32'h1F80_8500;
    localparam logic [ADDR_W-1:0] ADDR_PAD1  = WIN_BASE + 32'h0;
    localparam logic [ADDR_W-1:0] ADDR_PAD2  = WIN_BASE + 32'h4;
    localparam logic [ADDR_W-1:0] ADDR_STAT  = WIN_BASE + 32'h8;
    localparam logic [DATA_W-1:0] STAT_VALUE = 32'h0000_0001;

    // Source host bit for each pad bit, index 0 = pad LSB.
    localparam int PAD_SRC [PAD_W] = '{
        5, 14, 15, 4, 3, 0, 2, 1,
        12, 13, 10, 11, 6, 9, 7, 8
    };

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_PAD1   = 2'd1,
        SEL_PAD2   = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     req;
        reg_sel_e sel;
    } rd_req_t;

    typedef logic [N_PLAYERS-1:0][PAD_W-1:0] pad_bank_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        if (a == ADDR_PAD1)      s = SEL_PAD1;
        else if (a == ADDR_PAD2) s = SEL_PAD2;
        else if (a == ADDR_STAT) s = SEL_STATUS;
        else                     s = SEL_NONE;
        return s;
    endfunction

endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pad_encoder.sv
module pad_encoder
    import pad_win_pkg::*;
(
    input  logic [SRC_W-1:0] btn,
    output logic [PAD_W-1:0] pad
);
    genvar i;
    generate
        for (i = 0; i < PAD_W; i++) begin : g_bit
            assign pad[i] = ~btn[PAD_SRC[i]];
        end
    endgenerate
endmodule

// File: rtl/pad_read_port.sv
module pad_read_port
    import pad_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  pad_bank_t         pads,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    rd_req_t            req;
    logic [DATA_W-1:0]  mux_data;

    always_comb begin
        req.req = rd_en;
        req.sel = decode_addr(rd_addr);
    end

    always_comb begin
        mux_data = '0;
        if (req.req) begin
            unique case (req.sel)
                SEL_PAD1:   mux_data = {{(DATA_W-PAD_W){1'b0}}, pads[0]};
                SEL_PAD2:   mux_data = {{(DATA_W-PAD_W){1'b0}}, pads[1]};
                SEL_STATUS: mux_data = STAT_VALUE;
                default:    mux_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req.req;
            rd_data  <= mux_data;
        end
    end
endmodule

// File: rtl/pad_reg_window.sv
module pad_reg_window
    import pad_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BTN_W-1:0]  host_btn_p1,
    input  logic [BTN_W-1:0]  host_btn_p2,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [N_PLAYERS-1:0][BTN_W-1:0] host_words;
    logic [N_PLAYERS-1:0][SRC_W-1:0] synced;
    pad_bank_t                       pads;
    logic                            unused_hi_bits;

    assign host_words[0] = host_btn_p1;
    assign host_words[1] = host_btn_p2;
    assign unused_hi_bits = ^{host_btn_p1[BTN_W-1:SRC_W], host_btn_p2[BTN_W-1:SRC_W]};

    genvar p;
    generate
        for (p = 0; p < N_PLAYERS; p++) begin : g_player
            pad_sync #(
                .W      (SRC_W),
                .STAGES (SYNC_DEPTH)
            ) u_sync (
                .clk     (clk),
                .rst     (rst),
                .d_async (host_words[p][SRC_W-1:0]),
                .q_sync  (synced[p])
            );

            pad_encoder u_enc (
                .btn (synced[p]),
                .pad (pads[p])
            );
        end
    endgenerate

    pad_read_port u_port (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .pads     (pads),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/pad_win_chk.sv
module pad_win_chk
    import pad_win_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid
);
    AST_VALID_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid); // R7

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (!rd_valid && rd_data == '0)); // R7

    AST_UPPER_HALF_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (rd_addr == ADDR_PAD1 || rd_addr == ADDR_PAD2))
        |=> rd_data[DATA_W-1:PAD_W] == '0); // R3

    AST_STATUS_ONE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == ADDR_STAT) |=> rd_data == STAT_VALUE); // R4

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr != ADDR_PAD1 && rd_addr != ADDR_PAD2 && rd_addr != ADDR_STAT)
        |=> (rd_valid && rd_data == '0)); // R11
endmodule

bind pad_reg_window pad_win_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
);

// File: tb/sim_pad_reg_window.sv
`timescale 1ns/1ps
module sim_pad_reg_window;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] host_btn_p1, host_btn_p2;
    logic        rd_en;
    logic [31:0] rd_addr;
    logic [31:0] rd_data;
    logic        rd_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [31:0] A_P1 = 32'h1F80_8500;
    localparam logic [31:0] A_P2 = 32'h1F80_8504;
    localparam logic [31:0] A_ST = 32'h1F80_8508;

    always #10 clk = ~clk;

    pad_reg_window u0 (
        .clk(clk), .rst(rst),
        .host_btn_p1(host_btn_p1), .host_btn_p2(host_btn_p2),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // Pad encoding from R5 and R6.
    function automatic logic [15:0] enc(input logic [31:0] j);
        logic [7:0] lo, hi;
        lo = ~{j[1], j[2], j[0], j[3], j[4], j[15], j[14], j[5]};
        hi = ~{j[8], j[7], j[9], j[6], j[11], j[10], j[13], j[12]};
        return {hi, lo};
    endfunction

    // Behavioural reference: queues model the two-flop delay per player.
    logic [31:0] q1 [$];
    logic [31:0] q2 [$];
    logic        m_valid;
    logic [31:0] m_data;
    string       m_tag;

    task automatic model_reset();
        q1 = {32'd0, 32'd0};
        q2 = {32'd0, 32'd0};
    endtask

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
            m_valid = 1'b0;
            m_data  = 32'd0;
            m_tag   = "R12";
        end else begin
            m_valid = rd_en;
            m_data  = 32'd0;
            m_tag   = "R7";
            if (rd_en) begin
                if (rd_addr == A_P1)      begin m_data = {16'd0, enc(q1[0])}; m_tag = "R2"; end
                else if (rd_addr == A_P2) begin m_data = {16'd0, enc(q2[0])}; m_tag = "R2"; end
                else if (rd_addr == A_ST) begin m_data = 32'd1; m_tag = "R4"; end
                else                      m_tag = "R11";
            end
            void'(q1.pop_front());
            void'(q2.pop_front());
            q1.push_back(host_btn_p1);
            q2.push_back(host_btn_p2);
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (cycles > 2) begin
            checks++;
            if (rd_valid !== m_valid || rd_data !== m_data) begin
                errors++;
                $display("FAIL %s model: valid=%0b data=%08h expected valid=%0b data=%08h",
                         m_tag, rd_valid, rd_data, m_valid, m_data);
            end
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Called at a negedge; issues a read and checks the response at the next negedge.
    task automatic rd_check(input logic [31:0] a, input logic [31:0] exp, input string tag);
        rd_en = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        rd_addr = 32'd0;
        checks++;
        if (rd_valid !== 1'b1 || rd_data !== exp) begin
            errors++;
            $display("FAIL %s addr=%08h: valid=%0b data=%08h expected data=%08h",
                     tag, a, rd_valid, rd_data, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; rd_en = 1'b0; rd_addr = 32'd0;
        host_btn_p1 = 32'h0000_0FFF; host_btn_p2 = 32'hFFFF_0000;
        repeat (3) @(negedge clk);
        checks++;
        if (rd_valid !== 1'b0 || rd_data !== 32'd0) begin
            errors++;
            $display("FAIL R12 reset outputs: valid=%0b data=%08h expected 0/00000000", rd_valid, rd_data);
        end
        rst = 1'b0;
        rd_check(A_P1, 32'h0000_FFFF, "R12");    // first edge after reset
        host_btn_p1 = 32'd0; host_btn_p2 = 32'd0;
        settle();
        rd_check(A_P1, 32'h0000_FFFF, "R3");
        rd_check(A_P2, 32'h0000_FFFF, "R3");
        rd_check(A_ST, 32'h0000_0001, "R4");

        // R1: latency across the two flops.
        host_btn_p1 = 32'h0000_0001;
        rd_check(A_P1, 32'h0000_FFFF, "R1");
        rd_check(A_P1, 32'h0000_FFFF, "R1");
        rd_check(A_P1, 32'h0000_FFDF, "R1");

        // R5: single bits of the low byte, walking.
        for (int b = 0; b < 16; b++) begin
            host_btn_p1 = 32'd1 << b;
            settle();
            rd_check(A_P1, {16'd0, enc(32'd1 << b)}, (b == 5 || b < 5 || b == 14 || b == 15) ? "R5" : "R6");
        end
        host_btn_p1 = 32'd1 << 5;
        settle();
        rd_check(A_P1, 32'h0000_FFFE, "R5");    // bit 5 -> pad bit 0
        host_btn_p1 = 32'd1 << 1;
        settle();
        rd_check(A_P1, 32'h0000_FF7F, "R5");    // bit 1 -> pad bit 7
        host_btn_p1 = 32'd1 << 12;
        settle();
        rd_check(A_P1, 32'h0000_FEFF, "R6");    // bit 12 -> pad bit 8
        host_btn_p1 = 32'd1 << 8;
        settle();
        rd_check(A_P1, 32'h0000_7FFF, "R6");    // bit 8 -> pad bit 15

        // R8: independence of the two players.
        host_btn_p1 = 32'h0000_0001;
        host_btn_p2 = 32'h0000_0204;
        settle();
        rd_check(A_P2, {16'd0, enc(32'h0000_0204)}, "R8");
        rd_check(A_P1, {16'd0, enc(32'h0000_0001)}, "R8");
        host_btn_p1 = 32'h0000_003F;
        settle();
        rd_check(A_P1, {16'd0, enc(32'h0000_003F)}, "R8");
        rd_check(A_P2, {16'd0, enc(32'h0000_0204)}, "R8");

        // R10: upper host bits have no effect.
        host_btn_p1 = 32'hFFFF_003F;
        host_btn_p2 = 32'hA5A5_0000;
        settle();
        rd_check(A_P1, {16'd0, enc(32'h0000_003F)}, "R10");
        rd_check(A_P2, 32'h0000_FFFF, "R10");

        // R9: return to zero without local reset.
        host_btn_p1 = 32'h0000_FFFF;
        settle();
        rd_check(A_P1, 32'h0000_0000, "R9");
        host_btn_p1 = 32'd0;
        settle();
        rd_check(A_P1, 32'h0000_FFFF, "R9");

        // R11: unmapped addresses.
        rd_check(32'h1F80_850C, 32'd0, "R11");
        rd_check(32'h1F80_8502, 32'd0, "R11");
        rd_check(32'h0000_0000, 32'd0, "R11");

        // R7: back-to-back reads, then idle.
        rd_check(A_ST, 32'd1, "R7");
        rd_check(A_P2, 32'h0000_FFFF, "R7");
        @(negedge clk);
        checks++;
        if (rd_valid !== 1'b0) begin
            errors++;
            $display("FAIL R7 idle: valid=%0b expected 0", rd_valid);
        end

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule